// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Monitor

This block sits on the command pins of a single-data-rate SDRAM. It samples clock enable, chip select, the three strobes, the data mask, the bank select and the address on every rising edge, and turns each sample into a named command code. For every bank it tracks whether a row is open and which row it is. It follows the clock-enable history so that frozen cycles, power-down entry and self-refresh entry are told apart. It reports protocol misuse on single-cycle error outputs. It holds no memory array. It can serve as a bus checker beside a controller, or as the front end of a device model.

The data mask is handled with its two different latencies. On the write side the mask applies to the data of the same sample. On the read side the mask sets the output buffers to high impedance two samples later. All outputs are registered, and they change at the edge that samples the inputs they describe.

Top module: `sdcmd_monitor`

## Requirements
- R1: With cs_n high and the previous and current CKE samples both high, the sample decodes as NOP (code 0), whatever ras_n, cas_n, we_n, ba and addr carry, and no bank state changes.
- R2: With the previous CKE sample high and cs_n low, the strobe pattern {ras_n,cas_n,we_n} decodes as follows: 000 gives mode set (1); 001 gives auto-refresh (2), or self-refresh entry (3) if cke is low in that sample; 011 gives activate (4); 101 gives read (5), or read with auto-precharge (6) if addr[10] is high; 100 gives write (7), or write with auto-precharge (8) if addr[10] is high; 010 gives precharge (9), or precharge-all (10) if addr[10] is high; 110 gives burst stop (11); 111 gives NOP (0).
- R3: An activate to a closed bank opens it and stores addr as that bank's row in open_row[ba*12 +: 12]. The ba values 0, 1, 2 and 3 select banks 0 to 3, and bank_open bit i belongs to bank i.
- R4: A precharge closes bank ba. A precharge-all closes every bank whatever ba is. A closed bank keeps its last row value on open_row.
- R5: A read or write with auto-precharge to an open bank closes that bank at the same edge. A plain read or write leaves the bank open.
- R6: A read or write of either kind to a closed bank pulses err_closed for one cycle and changes no bank state.
- R7: An activate to an open bank pulses err_act_open and leaves the stored row unchanged.
- R8: Mode set, auto-refresh or self-refresh entry while any bank is open pulses err_ref_open. Bank state stays as it was.
- R9: cke_state shows the last sampled CKE. When that previous sample was low, the current sample decodes as frozen (13) and changes no bank state. When the previous sample was high and the current one is low, a deselect or a 111 pattern decodes as power-down entry (12).
- R10: A sample whose previous CKE was low, whose current CKE is high and which has cs_n low with a pattern other than 111 pulses err_cke, because the command came without a full cycle of CKE high.
- R11: wr_mask equals the dqm of the same sample (write latency 0), independent of cs_n and cke.
- R12: rd_oe after the edge of sample n equals the inverse of dqm at sample n-2 (read latency 2).
- R13: During reset, cmd_code is 0, all banks are closed with rows 0, every error is 0, cke_state is 1, wr_mask is 1 and rd_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| dqm | input | 1 | Data mask pin |
| ba | input | BA_W (2) | Bank select |
| addr | input | ADDR_W (12) | Multiplexed row/column address; bit AP_BIT selects auto-precharge / all banks |
| cmd_code | output | 4 | Decoded command code of the last sample |
| cke_state | output | 1 | Last sampled clock enable |
| bank_open | output | NUM_BANKS (4) | One bit per bank, set while a row is open |
| open_row | output | NUM_BANKS*ADDR_W (48) | Stored row of each bank, bank i at bits i*ADDR_W upward |
| wr_mask | output | 1 | Write data of this sample is masked |
| rd_oe | output | 1 | Read output buffers may drive in this cycle |
| err_closed | output | 1 | Column access to a closed bank |
| err_act_open | output | 1 | Activate to an already open bank |
| err_ref_open | output | 1 | Mode set or refresh with a bank open |
| err_cke | output | 1 | Command issued in the cycle CKE returned high |

## Verification
The bound checker checks several things on every cycle. A precharge-all leaves every bank closed. An error on a column access or on an activate leaves the bank vector and the stored rows untouched. A frozen cycle changes nothing. Each error flag appears only together with the command code it belongs to. Both data-mask latencies are checked against the sampled dqm. The bench must show the decode itself and the bank and row bookkeeping. It sweeps every pairing of previous and current CKE, every strobe pattern, both auto-precharge values and every bank against an independent bank model, and then runs directed ordering scenarios: a double activate, refresh with a bank open, column access after auto-precharge, and a command in the exit cycle of CKE.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    // Command codes reported on cmd_code
    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_MODE = 4'd1,
        CMD_AREF = 4'd2,
        CMD_SREF = 4'd3,
        CMD_ACT  = 4'd4,
        CMD_RD   = 4'd5,
        CMD_RDA  = 4'd6,
        CMD_WR   = 4'd7,
        CMD_WRA  = 4'd8,
        CMD_PRE  = 4'd9,
        CMD_PREA = 4'd10,
        CMD_BST  = 4'd11,
        CMD_PDN  = 4'd12,
        CMD_FRZ  = 4'd13
    } cmd_e;

    function automatic logic is_column(cmd_e c);
        return (c == CMD_RD) || (c == CMD_RDA) || (c == CMD_WR) || (c == CMD_WRA);
    endfunction

    function automatic logic is_refresh_like(cmd_e c);
        return (c == CMD_MODE) || (c == CMD_AREF) || (c == CMD_SREF);
    endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
    import sdcmd_pkg::*;
(
    input  logic cke_prev,
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    input  logic ap,
    output cmd_e cmd,
    output logic early_cmd
);

    logic [2:0] strobes;

    assign strobes = {ras_n, cas_n, we_n};

    always_comb begin
        cmd       = CMD_NOP;
        early_cmd = 1'b0;
        if (!cke_prev) begin
            // Frozen cycle; a real command in the exit cycle is misuse (R10)
            cmd       = CMD_FRZ;
            early_cmd = cke && !cs_n && (strobes != 3'b111);
        end else if (cs_n) begin
            cmd = cke ? CMD_NOP : CMD_PDN;
        end else begin
            unique case (strobes)
                3'b000:  cmd = CMD_MODE;
                3'b001:  cmd = cke ? CMD_AREF : CMD_SREF;
                3'b011:  cmd = CMD_ACT;
                3'b101:  cmd = ap ? CMD_RDA : CMD_RD;
                3'b100:  cmd = ap ? CMD_WRA : CMD_WR;
                3'b010:  cmd = ap ? CMD_PREA : CMD_PRE;
                3'b110:  cmd = CMD_BST;
                3'b111:  cmd = cke ? CMD_NOP : CMD_PDN;
                default: cmd = CMD_NOP;
            endcase
        end
    end

endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
    import sdcmd_pkg::*;
#(
    parameter int ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd,
    input  logic             sel,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             err_closed,
    output logic             err_act
);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        err_closed = sel && is_column(cmd) && !st_q.open;
        err_act    = sel && (cmd == CMD_ACT) && st_q.open;
        unique case (cmd)
            CMD_ACT: begin
                if (sel && !st_q.open) begin
                    st_d.open = 1'b1;
                    st_d.row  = row_in;
                end
            end
            CMD_PRE:  if (sel) st_d.open = 1'b0;
            CMD_PREA: st_d.open = 1'b0;
            CMD_RDA, CMD_WRA: if (sel) st_d.open = 1'b0;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o = st_q.open;
    assign row_o  = st_q.row;

endmodule

// File: rtl/sdcmd_dqm.sv
module sdcmd_dqm #(
    parameter int LAT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dqm,
    output logic wr_mask,
    output logic rd_oe
);

    // Stage 0 is the same-sample mask, stage LAT the delayed read mask
    logic [LAT:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[LAT-1:0], dqm};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign wr_mask = pipe_q[0];
    assign rd_oe   = ~pipe_q[LAT];

endmodule

// File: rtl/sdcmd_monitor.sv
module sdcmd_monitor
    import sdcmd_pkg::*;
#(
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 12,
    parameter int AP_BIT     = 10,
    parameter int RD_DQM_LAT = 2,
    localparam int BA_W      = $clog2(NUM_BANKS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cke,
    input  logic                        cs_n,
    input  logic                        ras_n,
    input  logic                        cas_n,
    input  logic                        we_n,
    input  logic                        dqm,
    input  logic [BA_W-1:0]             ba,
    input  logic [ADDR_W-1:0]           addr,
    output logic [3:0]                  cmd_code,
    output logic                        cke_state,
    output logic [NUM_BANKS-1:0]        bank_open,
    output logic [NUM_BANKS*ADDR_W-1:0] open_row,
    output logic                        wr_mask,
    output logic                        rd_oe,
    output logic                        err_closed,
    output logic                        err_act_open,
    output logic                        err_ref_open,
    output logic                        err_cke
);

    typedef struct packed {
        logic cke;
        cmd_e cmd;
        logic e_closed;
        logic e_act;
        logic e_ref;
        logic e_cke;
    } mon_t;

    mon_t st_d, st_q;

    cmd_e                 dec_cmd;
    logic                 dec_early;
    logic [NUM_BANKS-1:0] closed_vec;
    logic [NUM_BANKS-1:0] act_vec;

    sdcmd_decode u_decode (
        .cke_prev  (st_q.cke),
        .cke       (cke),
        .cs_n      (cs_n),
        .ras_n     (ras_n),
        .cas_n     (cas_n),
        .we_n      (we_n),
        .ap        (addr[AP_BIT]),
        .cmd       (dec_cmd),
        .early_cmd (dec_early)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (ba == BA_W'(b));
        sdcmd_bank #(.ROW_W(ADDR_W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .cmd        (dec_cmd),
            .sel        (sel),
            .row_in     (addr),
            .open_o     (bank_open[b]),
            .row_o      (open_row[b*ADDR_W +: ADDR_W]),
            .err_closed (closed_vec[b]),
            .err_act    (act_vec[b])
        );
    end

    sdcmd_dqm #(.LAT(RD_DQM_LAT)) u_dqm (
        .clk     (clk),
        .rst_n   (rst_n),
        .dqm     (dqm),
        .wr_mask (wr_mask),
        .rd_oe   (rd_oe)
    );

    always_comb begin
        st_d          = st_q;
        st_d.cke      = cke;
        st_d.cmd      = dec_cmd;
        st_d.e_closed = |closed_vec;
        st_d.e_act    = |act_vec;
        st_d.e_ref    = is_refresh_like(dec_cmd) && (|bank_open);
        st_d.e_cke    = dec_early;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cke <= 1'b1;
            st_q.cmd <= CMD_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_code     = st_q.cmd;
    assign cke_state    = st_q.cke;
    assign err_closed   = st_q.e_closed;
    assign err_act_open = st_q.e_act;
    assign err_ref_open = st_q.e_ref;
    assign err_cke      = st_q.e_cke;

endmodule

// File: rtl/sdcmd_monitor_chk.sv
module sdcmd_monitor_chk #(
    parameter int NUM_BANKS  = 4,
    parameter int ADDR_W     = 12,
    parameter int RD_DQM_LAT = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        dqm,
    input logic [3:0]                  cmd_code,
    input logic [NUM_BANKS-1:0]        bank_open,
    input logic [NUM_BANKS*ADDR_W-1:0] open_row,
    input logic                        wr_mask,
    input logic                        rd_oe,
    input logic                        err_closed,
    input logic                        err_act_open,
    input logic                        err_ref_open,
    input logic                        err_cke
);

    logic [2:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cyc_q <= '0;
        else if (cyc_q != 3'd7)  cyc_q <= cyc_q + 3'd1;
    end

    a_r4_prea_closes_all: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd10) |-> (bank_open == '0));

    a_r6_closed_access_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        err_closed |-> ($stable(bank_open) && (cmd_code inside {4'd5, 4'd6, 4'd7, 4'd8})));

    a_r7_double_act_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
        err_act_open |-> ($stable(open_row) && $stable(bank_open) && (cmd_code == 4'd4)));

    a_r8_refresh_flag_code: assert property (@(posedge clk) disable iff (!rst_n)
        err_ref_open |-> (cmd_code inside {4'd1, 4'd2, 4'd3}));

    a_r9_frozen_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_code == 4'd13) |-> ($stable(bank_open) && $stable(open_row)));

    a_r10_early_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        err_cke |-> (cmd_code == 4'd13));

    a_r11_write_mask_same: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q >= 3'd1) |-> (wr_mask == $past(dqm)));

    if (RD_DQM_LAT == 2) begin : g_rd_lat
        a_r12_read_mask_two: assert property (@(posedge clk) disable iff (!rst_n)
            (cyc_q >= 3'd3) |-> (rd_oe == !$past(wr_mask, 2)));
    end

endmodule

bind sdcmd_monitor sdcmd_monitor_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .ADDR_W     (ADDR_W),
    .RD_DQM_LAT (RD_DQM_LAT)
) u_chk (.*);

// File: tb/sdcmd_monitor_tb.sv
module sdcmd_monitor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_i = 1'b1, cs_n_i = 1'b1, ras_n_i = 1'b1, cas_n_i = 1'b1, we_n_i = 1'b1;
    logic        dqm_i = 1'b1;
    logic [1:0]  ba_i = '0;
    logic [11:0] addr_i = '0;

    logic [3:0]  cmd_code;
    logic        cke_state, wr_mask, rd_oe;
    logic [3:0]  bank_open;
    logic [47:0] open_row;
    logic        err_closed, err_act_open, err_ref_open, err_cke;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Reference model state
    logic        m_open [4];
    logic [11:0] m_row  [4];
    logic        m_cke;
    logic        h1, h2;

    always #4 clk = ~clk;

    sdcmd_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .cke(cke_i), .cs_n(cs_n_i), .ras_n(ras_n_i),
        .cas_n(cas_n_i), .we_n(we_n_i), .dqm(dqm_i), .ba(ba_i), .addr(addr_i),
        .cmd_code(cmd_code), .cke_state(cke_state), .bank_open(bank_open),
        .open_row(open_row), .wr_mask(wr_mask), .rd_oe(rd_oe),
        .err_closed(err_closed), .err_act_open(err_act_open),
        .err_ref_open(err_ref_open), .err_cke(err_cke)
    );

    task automatic chk(input string tag, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s (%s): got %0h expected %0h", tag, req, act, exp);
        end
    endtask

    function automatic int exp_code(input logic pc, k, s, r, c, w, ap);
        if (!pc) return 13;
        if (s)   return k ? 0 : 12;
        case ({r, c, w})
            3'b000: return 1;
            3'b001: return k ? 2 : 3;
            3'b011: return 4;
            3'b101: return ap ? 6 : 5;
            3'b100: return ap ? 8 : 7;
            3'b010: return ap ? 10 : 9;
            3'b110: return 11;
            default: return k ? 0 : 12;
        endcase
    endfunction

    task automatic step(input string tag, input logic k, s, r, c, w, dq,
                        input logic [1:0] b, input logic [11:0] a);
        int   code;
        logic ec, ea, er, ek, any, exp_oe;
        cke_i = k; cs_n_i = s; ras_n_i = r; cas_n_i = c; we_n_i = w;
        dqm_i = dq; ba_i = b; addr_i = a;
        code = exp_code(m_cke, k, s, r, c, w, a[10]);
        any  = m_open[0] | m_open[1] | m_open[2] | m_open[3];
        ec   = (code >= 5 && code <= 8) && !m_open[b];
        ea   = (code == 4) && m_open[b];
        er   = (code >= 1 && code <= 3) && any;
        ek   = !m_cke && k && !s && ({r, c, w} != 3'b111);
        if (code == 4 && !m_open[b]) begin m_open[b] = 1'b1; m_row[b] = a; end
        if (code == 9) m_open[b] = 1'b0;
        if (code == 10) for (int i = 0; i < 4; i++) m_open[i] = 1'b0;
        if ((code == 6 || code == 8) && m_open[b]) m_open[b] = 1'b0;
        exp_oe = !h2; h2 = h1; h1 = dq; m_cke = k;
        @(posedge clk); #2;
        chk(tag, "R2 cmd_code", 64'(cmd_code), 64'(code));
        chk(tag, "R3/R4 bank_open", 64'(bank_open),
            64'({m_open[3], m_open[2], m_open[1], m_open[0]}));
        chk(tag, "R3 open_row", 64'(open_row), 64'({m_row[3], m_row[2], m_row[1], m_row[0]}));
        chk(tag, "R6 err_closed", 64'(err_closed), 64'(ec));
        chk(tag, "R7 err_act_open", 64'(err_act_open), 64'(ea));
        chk(tag, "R8 err_ref_open", 64'(err_ref_open), 64'(er));
        chk(tag, "R10 err_cke", 64'(err_cke), 64'(ek));
        chk(tag, "R9 cke_state", 64'(cke_state), 64'(k));
        chk(tag, "R11 wr_mask", 64'(wr_mask), 64'(dq));
        chk(tag, "R12 rd_oe", 64'(rd_oe), 64'(exp_oe));
    endtask

    // Pattern helpers: {ras,cas,we}
    task automatic nop(input string tag, input logic dq);
        step(tag, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, dq, 2'd0, 12'h000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not complete, got hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_open[i] = 1'b0; m_row[i] = '0; end
        m_cke = 1'b1; h1 = 1'b1; h2 = 1'b1;
        repeat (3) @(posedge clk);
        #2;
        // R13 reset values
        chk("R13", "cmd", 64'(cmd_code), 64'd0);
        chk("R13", "bank_open", 64'(bank_open), 64'd0);
        chk("R13", "open_row", 64'(open_row), 64'd0);
        chk("R13", "errors", 64'({err_closed, err_act_open, err_ref_open, err_cke}), 64'd0);
        chk("R13", "cke_state", 64'(cke_state), 64'd1);
        chk("R13", "wr_mask", 64'(wr_mask), 64'd1);
        chk("R13", "rd_oe", 64'(rd_oe), 64'd0);
        rst_n = 1'b1;

        // R1 deselect with a full activate pattern on the other pins
        step("R1", 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 12'h555);
        step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 12'h7FF);
        // R3 activates
        step("R3", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 12'h123);
        step("R3", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 12'h0AB);
        // R7 activate to open bank 2
        step("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 12'h777);
        // R8 auto-refresh and mode set with banks open
        step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 12'h000);
        step("R8", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 12'h032);
        // R6 read and write to closed bank 1
        step("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd1, 12'h010);
        step("R6", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 12'h410);
        // R5 plain write keeps bank 2 open, read with auto-precharge closes it
        step("R5", 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 12'h004);
        step("R5", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 12'h404);
        step("R5", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'd2, 12'h004);
        // R4 precharge one bank, then precharge-all with ba pointing elsewhere
        step("R4", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 12'h000);
        step("R4", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 12'h3C1);
        step("R4", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 12'hA5A);
        step("R4", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 12'h400);
        // R9 power-down entry, frozen activate, R10 command in exit cycle
        step("R9", 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 12'h000);
        step("R9", 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 12'h111);
        step("R10", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 12'h222);
        step("R9", 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 12'h333);
        // R2 self-refresh entry after closing all
        step("R2", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 12'h400);
        step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 12'h000);
        step("R9", 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 12'h000);
        // R11/R12 dqm sequence over idle cycles
        nop("R11", 1'b1); nop("R12", 1'b0); nop("R12", 1'b0);
        nop("R12", 1'b1); nop("R11", 1'b0); nop("R12", 1'b1); nop("R12", 1'b0);

        // Sweep: previous/current CKE, cs and strobes, auto-precharge bit, bank
        for (int pc = 0; pc < 2; pc++)
            for (int k = 0; k < 2; k++)
                for (int p = 0; p < 16; p++)
                    for (int ap = 0; ap < 2; ap++)
                        for (int b = 0; b < 4; b++) begin
                            logic [11:0] a;
                            a = 12'(p * 37 + b * 5 + pc * 701);
                            a[10] = ap[0];
                            step("R2", pc[0], 1'b1, 1'b1, 1'b1, 1'b1, p[1] ^ b[0], 2'(b), 12'h000);
                            step("R2", k[0], p[3], p[2], p[1], p[0], p[0] ^ ap[0], 2'(b), a);
                        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule